// File: doc/BRIEF.md
# Streaming Mean-Variance Pulse Detector

This block watches a stream of complex samples and raises a flag when a sample's power departs from the recent background by more than a programmable margin. Samples arrive on every clock, but only one in four is processed. Each processed sample is reduced to its squared magnitude. The block keeps two exponentially weighted running statistics: the mean of the power, and the mean of the squared deviation of the power from that mean. A pulse is declared when the squared deviation reaches the threshold times the tracked variance.

The forgetting factor is one LSB short of unity in L fractional bits. The weight given to a new sample is therefore a single LSB, so each update needs only a shift-and-add and no real multiplier. A surrounding blanking controller drives the update-enable low so that the statistics freeze while a pulse is being handled. A load strobe presets both statistics, for example to skip the long settling time after start-up. The decimation enable is exported so that downstream timing can follow the processing cadence.

Top module: `pulse_stat_detector`

## Requirements
- R1: `sampleEn` is high in the first clock after reset release and then exactly one clock in every DECIM (4). Every pipeline and statistic register advances only on a clock where `sampleEn` is high.
- R2: Across a clock edge where `sampleEn` is low and `loadInit` is low, `meanOut`, `varOut` and `pulseFlag` do not change.
- R3: The power of a sample is re² + im², a 2N-bit unsigned value. Here re and im are the top N bits of each 16-bit rail, read as two's-complement. Starting from a zero mean, one enabled update makes the raw `meanOut` equal to that power.
- R4: The mean is 2N+L bits with L fractional bits. On each enabled update it becomes power + floor(mean·(2^L−1)/2^L), kept to 2N+L bits.
- R5: The deviation is the power delayed by one enabled step minus the integer part of the mean (mean >> L), taken as a signed 2N-bit value. Its square is a 4N-bit term. The variance (4N+L bits) updates as that term + floor(var·(2^L−1)/2^L).
- R6: On each enabled step, `pulseFlag` is set to (squared deviation ≥ `thresh` × (var >> L)). Equality counts as a pulse.
- R7: On an enabled step with `updEn` low, the mean and variance keep their values. The pipeline and `pulseFlag` still advance.
- R8: `loadInit` copies `meanInit` and `varInit` into the statistics at the next clock edge, whether or not `sampleEn` is high. It takes priority over a normal update.
- R9: While reset is asserted and just after release, `meanOut`, `varOut` and `pulseFlag` are zero.
- R10: A sample captured on an enabled step produces its detection result in `pulseFlag` after the 7th enabled step, counting the capture step as the first.
- R11: When the integer part of the variance is zero, every enabled step sets `pulseFlag`, whatever the deviation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxRe | input | 16 | Real rail of the input sample |
| rxIm | input | 16 | Imaginary rail of the input sample |
| thresh | input | L | Detection threshold multiplier |
| meanInit | input | 2N+L | Preset value for the mean |
| varInit | input | 4N+L | Preset value for the variance |
| loadInit | input | 1 | Strobe that copies the preset values |
| updEn | input | 1 | Allows statistic updates on enabled steps |
| meanOut | output | 2N+L | Current mean, L fractional bits |
| varOut | output | 4N+L | Current variance, L fractional bits |
| pulseFlag | output | 1 | Pulse detected on the latest enabled step |
| sampleEn | output | 1 | Decimation enable, one clock in four |

## Verification
The assertions assume that `loadInit` is a single-clock strobe whose preset values are stable during the clock in which it is high. They also assume that `updEn` and `thresh` are ordinary levels sampled at the clock. The stimulus changes every input half a cycle away from the rising edge, so each input is stable at the edge that samples it. It drops `loadInit` after exactly one edge. It uses full-range random rails for the noisy run and hand-chosen samples (power 5746, full-scale 127) where an exact value is expected.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // strobes from the sequencing control into the arithmetic path
  typedef struct packed {
    logic stepEn;  // decimated step, advances the pipeline
    logic statEn;  // step on which the statistics may update
    logic loadEn;  // preset the statistics
  } stepCtl_t;
endpackage

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int DECIM = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     updEn,
  input  logic     loadInit,
  output stepCtl_t ctl
);
  localparam int PH_W = $clog2(DECIM);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  always_comb begin
    ctl.stepEn = (phase == '0);
    ctl.statEn = ctl.stepEn & updEn;
    ctl.loadEn = loadInit;
  end
endmodule

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int N    = 8,
  parameter int L    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepCtl_t           ctl,
  input  logic [IN_W-1:0]    rxRe,
  input  logic [IN_W-1:0]    rxIm,
  input  logic [L-1:0]       thresh,
  input  logic [2*N+L-1:0]   meanInit,
  input  logic [4*N+L-1:0]   varInit,
  output logic [2*N+L-1:0]   meanOut,
  output logic [4*N+L-1:0]   varOut,
  output logic               pulseFlag
);
  localparam int PW = 2 * N;   // power width
  localparam int MW = PW + L;  // mean width
  localparam int SW = 4 * N;   // squared deviation width
  localparam int VW = SW + L;  // variance width
  localparam logic [L-1:0] MU = '1;

  // stage 1: capture top bits of each rail and square them
  logic [1:0][IN_W-1:0] railIn;
  assign railIn = {rxIm, rxRe};

  for (genvar g = 0; g < 2; g++) begin : gRail
    logic signed [N-1:0]  capReg;
    logic signed [PW-1:0] sqNext;
    logic [PW-1:0]        sqReg;
    assign sqNext = capReg * capReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capReg <= '0;
        sqReg  <= '0;
      end else if (ctl.stepEn) begin
        capReg <= railIn[g][IN_W-1 -: N];
        sqReg  <= sqNext;
      end
    end
  end

  if (IN_W > N) begin : gDrop
    logic unusedLowBits;
    assign unusedLowBits = ^{rxRe[IN_W-N-1:0], rxIm[IN_W-N-1:0]};
  end

  logic [PW-1:0]        pwrReg, pwrDly;
  logic signed [PW-1:0] devReg, devNext;
  logic signed [SW-1:0] devSqNext;
  logic [SW-1:0]        devSqReg;
  logic [MW-1:0]        meanReg, meanNext;
  logic [VW-1:0]        varReg, varNext;
  logic [MW+L-1:0]      meanProd;
  logic [VW+L-1:0]      varProd;
  logic [VW-1:0]        limit;
  logic                 hit, pulseReg;

  // deviation from the integer part of the mean
  assign devNext   = $signed(pwrDly) - $signed(meanReg[MW-1:L]);
  assign devSqNext = devReg * devReg;

  // weighted updates: new sample weight is one LSB of the fraction
  assign meanProd = {{L{1'b0}}, meanReg} * {{MW{1'b0}}, MU};
  assign meanNext = {{L{1'b0}}, pwrReg} + MW'(meanProd >> L);
  assign varProd  = {{L{1'b0}}, varReg} * {{VW{1'b0}}, MU};
  assign varNext  = {{L{1'b0}}, devSqReg} + VW'(varProd >> L);

  // detection against threshold times integer variance
  assign limit = {{SW{1'b0}}, thresh} * {{L{1'b0}}, varReg[VW-1:L]};
  assign hit   = ({{L{1'b0}}, devSqReg} >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrReg   <= '0;
      pwrDly   <= '0;
      devReg   <= '0;
      devSqReg <= '0;
      pulseReg <= 1'b0;
    end else if (ctl.stepEn) begin
      pwrReg   <= gRail[0].sqReg + gRail[1].sqReg;
      pwrDly   <= pwrReg;
      devReg   <= devNext;
      devSqReg <= devSqNext;
      pulseReg <= hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meanReg <= '0;
      varReg  <= '0;
    end else if (ctl.loadEn) begin
      meanReg <= meanInit;
      varReg  <= varInit;
    end else if (ctl.statEn) begin
      meanReg <= meanNext;
      varReg  <= varNext;
    end
  end

  assign meanOut   = meanReg;
  assign varOut    = varReg;
  assign pulseFlag = pulseReg;
endmodule

// File: rtl/pulse_stat_detector.sv
module pulse_stat_detector
  import psd_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int N     = 8,
  parameter int L     = 8,
  parameter int DECIM = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  rxRe,
  input  logic [IN_W-1:0]  rxIm,
  input  logic [L-1:0]     thresh,
  input  logic [2*N+L-1:0] meanInit,
  input  logic [4*N+L-1:0] varInit,
  input  logic             loadInit,
  input  logic             updEn,
  output logic [2*N+L-1:0] meanOut,
  output logic [4*N+L-1:0] varOut,
  output logic             pulseFlag,
  output logic             sampleEn
);
  stepCtl_t ctl;

  psd_ctrl #(.DECIM(DECIM)) i_ctrl (
    .clk(clk), .rstN(rstN), .updEn(updEn), .loadInit(loadInit), .ctl(ctl)
  );

  psd_datapath #(.IN_W(IN_W), .N(N), .L(L)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxRe(rxRe), .rxIm(rxIm),
    .thresh(thresh), .meanInit(meanInit), .varInit(varInit),
    .meanOut(meanOut), .varOut(varOut), .pulseFlag(pulseFlag)
  );

  assign sampleEn = ctl.stepEn;
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int N     = 8,
  parameter int L     = 8,
  parameter int DECIM = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleEn,
  input logic             loadInit,
  input logic             updEn,
  input logic [2*N+L-1:0] meanInit,
  input logic [4*N+L-1:0] varInit,
  input logic [2*N+L-1:0] meanOut,
  input logic [4*N+L-1:0] varOut,
  input logic             pulseFlag
);
  localparam int VW = 4 * N + L;
  localparam int G_W = $clog2(DECIM) + 1;
  localparam logic [G_W-1:0] G_LAST = G_W'(DECIM - 1);

  // clocks since the last enable; the next enable is due at G_LAST
  logic [G_W-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= G_LAST;
    else if (sampleEn) gapCnt <= '0;
    else gapCnt <= gapCnt + 1'b1;
  end

  assert_enable_due_R1: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt == G_LAST) |-> sampleEn);
  assert_enable_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt != G_LAST) |-> !sampleEn);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleEn && !loadInit) |=> ($stable(meanOut) && $stable(varOut) && $stable(pulseFlag)));
  assert_freeze_stats_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && !updEn && !loadInit) |=> ($stable(meanOut) && $stable(varOut)));
  assert_load_copies_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadInit |=> (meanOut == $past(meanInit) && varOut == $past(varInit)));
  assert_reset_clear_R9: assert property (@(posedge clk)
    $rose(rstN) |-> (meanOut == '0 && varOut == '0 && !pulseFlag));
  assert_zero_var_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && varOut[VW-1:L] == '0) |=> pulseFlag);
endmodule

bind pulse_stat_detector psd_checker #(.N(N), .L(L), .DECIM(DECIM)) i_psdChecker (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .loadInit(loadInit), .updEn(updEn),
  .meanInit(meanInit), .varInit(varInit), .meanOut(meanOut), .varOut(varOut),
  .pulseFlag(pulseFlag)
);

// File: tb/test_pulse_stat_detector.sv
module test_pulse_stat_detector;
  localparam int N = 8, L = 8, DECIM = 4;
  localparam int PW = 2 * N, MW = PW + L, SW = 4 * N, VW = SW + L;
  localparam longint MU = (64'sd1 <<< L) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] rxRe = '0, rxIm = '0;
  logic [L-1:0] thresh = '0;
  logic [MW-1:0] meanInit = '0;
  logic [VW-1:0] varInit = '0;
  logic loadInit = 1'b0, updEn = 1'b0;
  logic [MW-1:0] meanOut;
  logic [VW-1:0] varOut;
  logic pulseFlag, sampleEn;

  int nChecks = 0, nErr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pulse_stat_detector #(.IN_W(16), .N(N), .L(L), .DECIM(DECIM)) i_pulse_stat_detector (
    .clk(clk), .rstN(rstN), .rxRe(rxRe), .rxIm(rxIm), .thresh(thresh),
    .meanInit(meanInit), .varInit(varInit), .loadInit(loadInit), .updEn(updEn),
    .meanOut(meanOut), .varOut(varOut), .pulseFlag(pulseFlag), .sampleEn(sampleEn)
  );

  // reference model built from the requirement formulas
  longint mRe, mIm, mSqRe, mSqIm, mPwr, mDly, mDev, mDevSq, mMean, mVar;
  bit mPulse;
  int mPhase;

  function automatic longint topBits(input logic [15:0] v);
    logic signed [N-1:0] t;
    t = v[15 -: N];
    return longint'(t);
  endfunction

  always @(posedge clk or negedge rstN) begin
    longint nDev, nMean, nVar;
    if (!rstN) begin
      mRe = 0; mIm = 0; mSqRe = 0; mSqIm = 0; mPwr = 0; mDly = 0;
      mDev = 0; mDevSq = 0; mMean = 0; mVar = 0; mPulse = 0; mPhase = 0;
    end else begin
      nMean = mMean; nVar = mVar;
      if (mPhase == 0) begin
        mPulse = (mDevSq >= longint'(thresh) * (mVar >>> L));
        nDev = (mDly - (mMean >>> L)) & ((64'sd1 <<< PW) - 1);
        if (nDev >= (64'sd1 <<< (PW - 1))) nDev = nDev - (64'sd1 <<< PW);
        if (updEn) begin
          nMean = (mPwr + ((mMean * MU) >>> L)) & ((64'sd1 <<< MW) - 1);
          nVar  = (mDevSq + ((mVar * MU) >>> L)) & ((64'sd1 <<< VW) - 1);
        end
        mDevSq = mDev * mDev;
        mDev = nDev;
        mDly = mPwr;
        mPwr = mSqRe + mSqIm;
        mSqRe = mRe * mRe; mSqIm = mIm * mIm;
        mRe = topBits(rxRe); mIm = topBits(rxIm);
      end
      if (loadInit) begin nMean = longint'(meanInit); nVar = longint'(varInit); end
      mMean = nMean; mVar = nVar;
      mPhase = (mPhase + 1) % DECIM;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one decimated step: inputs driven half a cycle before the enabled edge
  task automatic step(input logic [15:0] re, input logic [15:0] im,
                      input logic upd, input logic ld);
    @(negedge clk);
    while (mPhase != 0) @(negedge clk);
    rxRe = re; rxIm = im; updEn = upd; loadInit = ld;
    @(negedge clk);
    loadInit = 1'b0;
  endtask

  task automatic testReset();
    check("R9 mean after reset", longint'(meanOut), 0);
    check("R9 var after reset", longint'(varOut), 0);
    check("R9 pulse after reset", longint'(pulseFlag), 0);
  endtask

  task automatic testCadence();
    longint pm, pv; bit pp;
    rxRe = 16'h5000; rxIm = 16'hB000; updEn = 1'b1;
    pm = longint'(meanOut); pv = longint'(varOut); pp = pulseFlag;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R1 enable cadence", longint'(sampleEn), longint'(mPhase == 0));
      if (mPhase != 1) begin
        check("R2 mean held", longint'(meanOut), pm);
        check("R2 var held", longint'(varOut), pv);
        check("R2 pulse held", longint'(pulseFlag), longint'(pp));
      end
      pm = longint'(meanOut); pv = longint'(varOut); pp = pulseFlag;
    end
  endtask

  task automatic testPower();
    meanInit = '0; varInit = '0; thresh = 8'd1;
    step(16'h0000, 16'h0000, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(16'h0000, 16'h0000, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(16'hC3A5, 16'h2D5A, 1'b0, 1'b0);
    step(16'hC3A5, 16'h2D5A, 1'b1, 1'b0);
    check("R3 power into zero mean", longint'(meanOut), 5746);
  endtask

  task automatic testThreshEdge();
    longint d;
    d = 64'sd5746 * 64'sd5746;
    meanInit = '0; varInit = VW'(d <<< L); thresh = 8'd1;
    step(16'hC3A5, 16'h2D5A, 1'b0, 1'b1);
    for (int i = 0; i < 7; i++) step(16'hC3A5, 16'h2D5A, 1'b0, 1'b0);
    check("R6 deviation equal to limit is a pulse", longint'(pulseFlag), 1);
    varInit = VW'((d + 1) <<< L);
    step(16'hC3A5, 16'h2D5A, 1'b0, 1'b1);
    step(16'hC3A5, 16'h2D5A, 1'b0, 1'b0);
    check("R6 deviation one below limit is quiet", longint'(pulseFlag), 0);
  endtask

  task automatic testNoise();
    meanInit = '0; varInit = '0; thresh = 8'd3;
    step(16'h0000, 16'h0000, 1'b1, 1'b1);
    for (int i = 0; i < 240; i++) begin
      step(16'($urandom), 16'($urandom), (i % 40) < 32, 1'b0);
      check("R4 mean tracks model", longint'(meanOut), mMean);
      check("R5 variance tracks model", longint'(varOut), mVar);
      check("R6 pulse tracks model", longint'(pulseFlag), longint'(mPulse));
    end
  endtask

  task automatic testFreeze();
    longint m0, v0;
    m0 = longint'(meanOut); v0 = longint'(varOut);
    for (int i = 0; i < 16; i++) begin
      step(16'($urandom), 16'($urandom), 1'b0, 1'b0);
      check("R7 mean frozen", longint'(meanOut), m0);
      check("R7 var frozen", longint'(varOut), v0);
    end
  endtask

  task automatic testLoad();
    meanInit = 24'h123456; varInit = 40'h12_3456_789A;
    step(16'h7000, 16'h7000, 1'b1, 1'b1);
    check("R8 load beats update (mean)", longint'(meanOut), 64'h123456);
    check("R8 load beats update (var)", longint'(varOut), 64'h12_3456_789A);
    meanInit = 24'h00ABCD; varInit = 40'h00_0001_2345;
    @(negedge clk);
    while (mPhase != 2) @(negedge clk);
    loadInit = 1'b1;
    @(negedge clk);
    loadInit = 1'b0;
    check("R8 load between steps (mean)", longint'(meanOut), 64'h00ABCD);
    check("R8 load between steps (var)", longint'(varOut), 64'h0000012345);
  endtask

  task automatic testZeroVar();
    meanInit = 24'h004000; varInit = '0; thresh = 8'hFF;
    step(16'h0000, 16'h0000, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      step(16'($urandom), 16'($urandom), 1'b0, 1'b0);
      check("R11 zero variance flags every step", longint'(pulseFlag), 1);
    end
  endtask

  task automatic testLatency();
    int k;
    meanInit = '0; varInit = VW'(64'sd1 <<< (20 + L)); thresh = 8'd1;
    step(16'h0000, 16'h0000, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step(16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R10 quiet before pulse", longint'(pulseFlag), 0);
    step(16'h7F00, 16'h7F00, 1'b0, 1'b0);
    k = 1;
    while (!pulseFlag && k < 12) begin
      step(16'h0000, 16'h0000, 1'b0, 1'b0);
      k++;
    end
    check("R10 steps from capture to flag", k, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCadence();
    testPower();
    testThreshEdge();
    testNoise();
    testFreeze();
    testLoad();
    testZeroVar();
    testLatency();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule